// File: doc/BRIEF.md
# Block Viterbi Decoder with Trellis Control

This block decodes hard-decision code symbols from a rate-1/2 convolutional code with constraint length 5, which gives 16 trellis states. It works one block at a time. A start pulse opens a block and picks how the state metrics begin. They can start from state zero, from a chosen state with a supplied metric, or from whatever the previous block left behind. Code-symbol pairs then arrive, at most one per cycle. Each pair runs an add-compare-select step over all 16 states, and the step's survivor decisions are stored in a buffer.

The last symbol of a block is marked. The decoder then traces back through the stored decisions. The trace starts either from the state with the smallest metric or from a known end state given by the user. When the encoder stopped on known information bits, that end state is those final four bits in reverse order. The traceback recovers the decoded bits from last to first. An output stage then presents them in their original order, one per cycle, each with a valid strobe. A busy flag covers the whole traceback and output phase.

Top module: `vit_block_decoder`

## Requirements
- R1: Encoder convention. The state is the last four input bits, with the newest bit in state bit 3, so the next state is {u, s[3:1]}. The expected pair for input u from state s uses the 5-bit word {u, s}. Symbol bit 0 is the parity of that word masked with 23 octal, and symbol bit 1 is the parity masked with 35 octal. A noise-free block from an encoder started at zero, with end state 0 given, decodes to exactly the input bits.
- R2: The branch metric is the Hamming distance (0 to 2) between the received pair and the expected pair. For next state n, the two candidate predecessors are {n[2:0],0} and {n[2:0],1}. The second candidate wins only when its sum is strictly smaller. Without a known end state, traceback starts from the smallest metric, and on a tie from the lowest state index.
- R3: Mode 0 (mode 3 behaves the same) loads metric 0 into state 0 and 255 into every other state. Reset leaves the metrics in this same condition.
- R4: Mode 1 loads the supplied value into the chosen start state and 0 into all other states.
- R5: Mode 2 leaves the metrics as the previous block ended them.
- R6: Metrics are 8 bits wide and saturate at 255. Before a step, if every metric has bit 7 set, 128 is subtracted from each candidate sum. Apart from that subtraction, the smallest metric never decreases.
- R7: When the end state is flagged as known, traceback starts from that state. A block whose last four information bits are 0,1,0,1 in time order ends in state 10.
- R8: At most 64 steps are stored per block. Symbols after the 64th are ignored, and the block yields min(count, 64) bits.
- R9: Decoded bits appear in the order of their symbols, one per cycle with `dec_valid` high. The last bit is presented in the cycle in which `busy` falls.
- R10: `busy` rises in the cycle after the marked last symbol and stays high until the last bit is presented. A start pulse while `busy` is high has no effect.
- R11: After reset, `busy` and `dec_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | Opens a block and applies `init_mode` |
| init_mode | input | 2 | 0/3 zero start, 1 seeded start, 2 keep metrics |
| seed_state | input | 4 | State loaded with `seed_metric` in mode 1 |
| seed_metric | input | 8 | Metric for the seeded state |
| sym_valid | input | 1 | A code-symbol pair is present |
| sym | input | 2 | Received hard-decision pair |
| blk_last | input | 1 | Marks the final symbol of the block (with `sym_valid`) |
| tail_known | input | 1 | Use `tail_state` as the traceback start |
| tail_state | input | 4 | Known end state, sampled with the last symbol |
| busy | output | 1 | Traceback or output in progress |
| dec_valid | output | 1 | `dec_bit` carries a decoded bit |
| dec_bit | output | 1 | Decoded information bit |

## Verification
The assertions assume three things about the inputs. `blk_last` only comes together with `sym_valid`. A start pulse never arrives in the same cycle as a symbol. The symbols of a block arrive only after its start pulse has been taken. The bench follows these rules. It drives each block as one start pulse followed by a contiguous run of symbols, with the marker on the final one. Its only out-of-phase start pulse is issued deliberately while `busy` is high, to show that it is ignored.

// File: rtl/vit_pkg.sv
package vit_pkg;
  localparam int CONSTR  = 5;
  localparam int SBITS   = CONSTR - 1;
  localparam int NSTATE  = 1 << SBITS;
  localparam int MWIDTH  = 8;
  localparam int MAXSTEP = 64;
  localparam int AWIDTH  = $clog2(MAXSTEP);

  localparam logic [CONSTR-1:0] POLY_A = 5'o23;
  localparam logic [CONSTR-1:0] POLY_B = 5'o35;
  localparam logic [MWIDTH-1:0] METRIC_INF = '1;
  localparam logic [MWIDTH:0]   RENORM_SUB = (MWIDTH+1)'(1) << (MWIDTH-1);

  typedef enum logic [1:0] {
    START_ZERO  = 2'd0,
    START_SEED  = 2'd1,
    START_KEEP  = 2'd2,
    START_ZERO2 = 2'd3
  } start_mode_e;

  typedef enum logic [1:0] {CTL_IDLE, CTL_RECV, CTL_FIND} ctl_e;
  typedef enum logic [1:0] {TB_IDLE, TB_WALK, TB_EMIT} tb_e;

  // expected symbol pair for input bit u leaving state prev
  function automatic logic [1:0] code_pair(input logic u, input logic [SBITS-1:0] prev);
    logic [CONSTR-1:0] word;
    word = {u, prev};
    return {^(word & POLY_B), ^(word & POLY_A)};
  endfunction

  // Hamming distance of two pairs, 0..2
  function automatic logic [1:0] sym_distance(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] x;
    x = a ^ b;
    return {x[1] & x[0], x[1] ^ x[0]};
  endfunction

  // add branch metric, optional renormalisation, saturate
  function automatic logic [MWIDTH-1:0] extend_metric(input logic [MWIDTH-1:0] m,
                                                     input logic [1:0] bm,
                                                     input logic renorm);
    logic [MWIDTH:0] s;
    s = {1'b0, m} + {{(MWIDTH-1){1'b0}}, bm};
    if (renorm) s = s - RENORM_SUB;
    if (s[MWIDTH]) return METRIC_INF;
    return s[MWIDTH-1:0];
  endfunction
endpackage

// File: rtl/vit_metric_bank.sv
module vit_metric_bank
  import vit_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           init_en,
  input  logic [1:0]                     init_mode,
  input  logic [SBITS-1:0]               seed_state,
  input  logic [MWIDTH-1:0]              seed_metric,
  input  logic                           step_en,
  input  logic [1:0]                     sym,
  output logic [NSTATE-1:0][MWIDTH-1:0]  metric,
  output logic [NSTATE-1:0]              choice,
  output logic                           renorm_evt
);
  always_comb begin
    renorm_evt = 1'b1;
    for (int s = 0; s < NSTATE; s++) renorm_evt = renorm_evt & metric[s][MWIDTH-1];
  end

  for (genvar ns = 0; ns < NSTATE; ns++) begin : g_acs
    localparam logic             IN_BIT = 1'((ns >> (SBITS-1)) & 1);
    localparam logic [SBITS-1:0] PRED0  = SBITS'((ns << 1) & (NSTATE-1));
    localparam logic [SBITS-1:0] PRED1  = PRED0 | SBITS'(1);
    logic [MWIDTH-1:0] sm_q, cand0, cand1, winner;
    logic take1;

    always_comb begin
      cand0  = extend_metric(metric[PRED0], sym_distance(sym, code_pair(IN_BIT, PRED0)), renorm_evt);
      cand1  = extend_metric(metric[PRED1], sym_distance(sym, code_pair(IN_BIT, PRED1)), renorm_evt);
      take1  = cand1 < cand0;
      winner = take1 ? cand1 : cand0;
    end

    assign choice[ns] = take1;
    assign metric[ns] = sm_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sm_q <= (ns == 0) ? '0 : METRIC_INF;
      end else if (init_en) begin
        case (init_mode)
          START_SEED: sm_q <= (seed_state == SBITS'(ns)) ? seed_metric : '0;
          START_KEEP: sm_q <= sm_q;
          default:    sm_q <= (ns == 0) ? '0 : METRIC_INF;
        endcase
      end else if (step_en) begin
        sm_q <= winner;
      end
    end
  end

  // R4
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_en && init_mode == START_SEED |=> metric[$past(seed_state)] == $past(seed_metric));
  // R3
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_en && (init_mode == START_ZERO || init_mode == START_ZERO2)
    |=> metric[0] == '0 && metric[NSTATE-1] == METRIC_INF);
  // R5
  keep_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_en && init_mode == START_KEEP && !step_en |=> $stable(metric));
endmodule

// File: rtl/vit_min_finder.sv
module vit_min_finder
  import vit_pkg::*;
(
  input  logic [NSTATE-1:0][MWIDTH-1:0] metric,
  output logic [SBITS-1:0]              best_state,
  output logic [MWIDTH-1:0]             best_metric
);
  // strict compare keeps the lowest index on ties
  always_comb begin
    best_state  = '0;
    best_metric = metric[0];
    for (int s = 1; s < NSTATE; s++) begin
      if (metric[s] < best_metric) begin
        best_metric = metric[s];
        best_state  = SBITS'(s);
      end
    end
  end
endmodule

// File: rtl/vit_traceback.sv
module vit_traceback
  import vit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AWIDTH-1:0] wr_addr,
  input  logic [NSTATE-1:0] wr_choice,
  input  logic              start,
  input  logic [SBITS-1:0]  start_state,
  input  logic [AWIDTH:0]   length,
  output logic              busy,
  output logic              bit_valid,
  output logic              bit_out
);
  logic [NSTATE-1:0]  surv_mem [MAXSTEP];
  tb_e                phase;
  logic [AWIDTH-1:0]  walk_ptr, emit_ptr, last_ptr;
  logic [SBITS-1:0]   walk_state;
  logic [MAXSTEP-1:0] bit_store;

  always_ff @(posedge clk) begin
    if (wr_en) surv_mem[wr_addr] <= wr_choice;
  end

  assign busy = (phase != TB_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= TB_IDLE;
      walk_ptr   <= '0;
      emit_ptr   <= '0;
      last_ptr   <= '0;
      walk_state <= '0;
      bit_store  <= '0;
      bit_valid  <= 1'b0;
      bit_out    <= 1'b0;
    end else begin
      bit_valid <= 1'b0;
      case (phase)
        TB_IDLE: begin
          if (start) begin
            phase      <= TB_WALK;
            walk_ptr   <= AWIDTH'(length - 1'b1);
            last_ptr   <= AWIDTH'(length - 1'b1);
            walk_state <= start_state;
          end
        end
        TB_WALK: begin
          // bits come out newest first; store them by step index
          bit_store[walk_ptr] <= walk_state[SBITS-1];
          walk_state <= {walk_state[SBITS-2:0], surv_mem[walk_ptr][walk_state]};
          walk_ptr   <= walk_ptr - 1'b1;
          if (walk_ptr == '0) begin
            phase    <= TB_EMIT;
            emit_ptr <= '0;
          end
        end
        TB_EMIT: begin
          bit_valid <= 1'b1;
          bit_out   <= bit_store[emit_ptr];
          emit_ptr  <= emit_ptr + 1'b1;
          if (emit_ptr == last_ptr) phase <= TB_IDLE;
        end
        default: phase <= TB_IDLE;
      endcase
    end
  end

  // R9
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(phase) == TB_EMIT);
  // R9
  last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bit_valid);
endmodule

// File: rtl/vit_block_decoder.sv
module vit_block_decoder
  import vit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_start,
  input  logic [1:0]        init_mode,
  input  logic [SBITS-1:0]  seed_state,
  input  logic [MWIDTH-1:0] seed_metric,
  input  logic              sym_valid,
  input  logic [1:0]        sym,
  input  logic              blk_last,
  input  logic              tail_known,
  input  logic [SBITS-1:0]  tail_state,
  output logic              busy,
  output logic              dec_valid,
  output logic              dec_bit
);
  ctl_e                          ctl;
  logic [AWIDTH:0]               step_cnt;
  logic                          tail_known_q;
  logic [SBITS-1:0]              tail_state_q;
  logic                          tb_busy;
  logic [NSTATE-1:0][MWIDTH-1:0] metric;
  logic [NSTATE-1:0]             choice;
  logic                          renorm_evt;
  logic [SBITS-1:0]              best_state;
  logic [MWIDTH-1:0]             best_metric;

  // named internal events
  logic accept_start, step_fire, close_block, tb_start;
  logic [SBITS-1:0] trace_from;

  assign busy         = (ctl == CTL_FIND) || tb_busy;
  assign accept_start = blk_start && !busy;
  assign step_fire    = (ctl == CTL_RECV) && sym_valid && !accept_start
                        && (step_cnt < (AWIDTH+1)'(MAXSTEP));
  assign close_block  = (ctl == CTL_RECV) && sym_valid && blk_last && !accept_start;
  assign tb_start     = (ctl == CTL_FIND) && (step_cnt != '0);
  assign trace_from   = tail_known_q ? tail_state_q : best_state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl          <= CTL_IDLE;
      step_cnt     <= '0;
      tail_known_q <= 1'b0;
      tail_state_q <= '0;
    end else if (accept_start) begin
      ctl      <= CTL_RECV;
      step_cnt <= '0;
    end else begin
      if (step_fire) step_cnt <= step_cnt + 1'b1;
      if (close_block) begin
        ctl          <= CTL_FIND;
        tail_known_q <= tail_known;
        tail_state_q <= tail_state;
      end
      if (ctl == CTL_FIND) ctl <= CTL_IDLE;
    end
  end

  vit_metric_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_en     (accept_start),
    .init_mode   (init_mode),
    .seed_state  (seed_state),
    .seed_metric (seed_metric),
    .step_en     (step_fire),
    .sym         (sym),
    .metric      (metric),
    .choice      (choice),
    .renorm_evt  (renorm_evt)
  );

  vit_min_finder u_min (
    .metric      (metric),
    .best_state  (best_state),
    .best_metric (best_metric)
  );

  vit_traceback u_tb (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (step_fire),
    .wr_addr     (step_cnt[AWIDTH-1:0]),
    .wr_choice   (choice),
    .start       (tb_start),
    .start_state (trace_from),
    .length      (step_cnt),
    .busy        (tb_busy),
    .bit_valid   (dec_valid),
    .bit_out     (dec_bit)
  );

  // R6
  metric_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && !renorm_evt |=> best_metric >= $past(best_metric));
  // R6
  renorm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && renorm_evt
    |=> ({1'b0, best_metric} + RENORM_SUB - (MWIDTH+1)'(2)) <= {1'b0, $past(best_metric)});
  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && blk_start |=> $stable(metric) && $stable(step_cnt));
  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_block |=> busy);
  // R8
  step_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt <= (AWIDTH+1)'(MAXSTEP));
endmodule

// File: tb/vit_block_decoder_test.sv
module vit_block_decoder_test;
  import vit_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              blk_start = 1'b0;
  logic [1:0]        init_mode = '0;
  logic [SBITS-1:0]  seed_state = '0;
  logic [MWIDTH-1:0] seed_metric = '0;
  logic              sym_valid = 1'b0;
  logic [1:0]        sym = '0;
  logic              blk_last = 1'b0;
  logic              tail_known = 1'b0;
  logic [SBITS-1:0]  tail_state = '0;
  logic              busy, dec_valid, dec_bit;

  vit_block_decoder uut (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .init_mode(init_mode),
    .seed_state(seed_state), .seed_metric(seed_metric), .sym_valid(sym_valid),
    .sym(sym), .blk_last(blk_last), .tail_known(tail_known), .tail_state(tail_state),
    .busy(busy), .dec_valid(dec_valid), .dec_bit(dec_bit)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    got_cnt = 0;
  bit    exp_q[$];
  string why_q[$];
  int    ref_sm[NSTATE];
  bit    ref_dec[MAXSTEP][NSTATE];
  int    sym_arr[128];
  bit    data_arr[128];
  bit    exp_bits[MAXSTEP];

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: pair bit1 = parity with 35 octal, bit0 = parity with 23 octal, word {u, state}
  function automatic int pair_of(int u, int st);
    int w;
    w = (u << SBITS) | st;
    return (($countones(w & 'o35) & 1) << 1) | ($countones(w & 'o23) & 1);
  endfunction

  // R6: saturate at 255, optional subtract of 128
  function automatic int grow(int m, int d, bit ren);
    int s;
    s = m + d;
    if (ren) s = s - 128;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic model(int mode, int seed_s, int seed_m, int n, bit known, int endst,
                       bit use_truth, string req);
    int steps;
    int st;
    int nsm[NSTATE];
    bit ren;
    if (mode == 1) begin
      foreach (ref_sm[s]) ref_sm[s] = 0;
      ref_sm[seed_s] = seed_m;
    end else if (mode != 2) begin
      foreach (ref_sm[s]) ref_sm[s] = 255;
      ref_sm[0] = 0;
    end
    steps = (n > MAXSTEP) ? MAXSTEP : n;
    for (int t = 0; t < steps; t++) begin
      ren = 1'b1;
      for (int s = 0; s < NSTATE; s++) if (ref_sm[s] < 128) ren = 1'b0;
      for (int ns = 0; ns < NSTATE; ns++) begin
        int u, a, b, ma, mb;
        u  = ns >> (SBITS-1);
        a  = (ns << 1) & (NSTATE-1);
        b  = a + 1;
        ma = grow(ref_sm[a], $countones(pair_of(u, a) ^ sym_arr[t]), ren);
        mb = grow(ref_sm[b], $countones(pair_of(u, b) ^ sym_arr[t]), ren);
        ref_dec[t][ns] = (mb < ma);
        nsm[ns] = (mb < ma) ? mb : ma;
      end
      ref_sm = nsm;
    end
    if (known) st = endst;
    else begin
      st = 0;
      for (int s = 1; s < NSTATE; s++) if (ref_sm[s] < ref_sm[st]) st = s;
    end
    for (int t = steps - 1; t >= 0; t--) begin
      exp_bits[t] = bit'(st >> (SBITS-1));
      st = ((st << 1) & (NSTATE-1)) | int'(ref_dec[t][st]);
    end
    for (int t = 0; t < steps; t++) begin
      exp_q.push_back(use_truth ? data_arr[t] : exp_bits[t]);
      why_q.push_back(req);
    end
  endtask

  task automatic make_clean(int n, bit flush, bit tail0101);
    int es = 0;
    int u;
    for (int i = 0; i < n; i++) begin
      u = $urandom_range(0, 1);
      if (flush && i >= n - SBITS) u = 0;
      if (tail0101 && i >= n - SBITS) u = (i - (n - SBITS)) & 1;
      data_arr[i] = bit'(u);
      sym_arr[i]  = pair_of(u, es);
      es = (u << (SBITS-1)) | (es >> 1);
    end
  endtask

  task automatic make_noisy(int n);
    for (int i = 0; i < n; i++) sym_arr[i] = $urandom_range(0, 3);
  endtask

  task automatic run_block(int mode, int seed_s, int seed_m, int n, bit known, int endst,
                           bit use_truth, bit poke, string req);
    int want;
    model(mode, seed_s, seed_m, n, known, endst, use_truth, req);
    want = (n > MAXSTEP) ? MAXSTEP : n;
    got_cnt = 0;
    @(negedge clk);
    blk_start   = 1'b1;
    init_mode   = 2'(mode);
    seed_state  = SBITS'(seed_s);
    seed_metric = MWIDTH'(seed_m);
    @(negedge clk);
    blk_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      sym_valid  = 1'b1;
      sym        = 2'(sym_arr[i]);
      blk_last   = (i == n - 1);
      tail_known = known;
      tail_state = SBITS'(endst);
      @(negedge clk);
    end
    sym_valid = 1'b0;
    blk_last  = 1'b0;
    // R10: busy right after the marked last symbol
    check(busy === 1'b1, "R10", int'(busy), 1);
    if (poke) begin
      // R10: start pulse while busy, zero-start mode would wipe kept metrics
      blk_start = 1'b1;
      init_mode = 2'd0;
      @(negedge clk);
      blk_start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    // R8: bit count per block
    check(got_cnt == want, "R8", got_cnt, want);
    // R9: every expected bit arrived
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);
    exp_q.delete();
    why_q.delete();
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin : monitor
    bit    e;
    string r;
    if (rst_n && dec_valid) begin
      got_cnt++;
      if (exp_q.size() == 0) check(1'b0, "R9", int'(dec_bit), -1);
      else begin
        e = exp_q.pop_front();
        r = why_q.pop_front();
        check(dec_bit === e, r, int'(dec_bit), int'(e));
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    foreach (ref_sm[s]) ref_sm[s] = 255;
    ref_sm[0] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    check(busy === 1'b0, "R11", int'(busy), 0);
    check(dec_valid === 1'b0, "R11", int'(dec_valid), 0);

    // R1: flushed clean block, known end state 0
    make_clean(32, 1'b1, 1'b0);
    run_block(0, 0, 0, 32, 1'b1, 0, 1'b1, 1'b0, "R1");
    // R7: block ending 0,1,0,1 ends in state 10
    make_clean(40, 1'b0, 1'b1);
    run_block(0, 0, 0, 40, 1'b1, 10, 1'b1, 1'b0, "R7");
    // R3: mode 3 alias of zero start, best-state traceback, clean
    make_clean(30, 1'b1, 1'b0);
    run_block(3, 0, 0, 30, 1'b0, 0, 1'b1, 1'b0, "R3");
    // R2: noisy symbols, best-state traceback with ties to lowest index
    make_noisy(48);
    run_block(0, 0, 0, 48, 1'b0, 0, 1'b0, 1'b0, "R2");
    // R7: noisy with a forced end state
    make_noisy(36);
    run_block(0, 0, 0, 36, 1'b1, 6, 1'b0, 1'b0, "R7");
    // R4: seeded start
    make_noisy(40);
    run_block(1, 5, 64, 40, 1'b0, 0, 1'b0, 1'b0, "R4");
    make_noisy(20);
    run_block(1, 12, 200, 20, 1'b0, 0, 1'b0, 1'b0, "R4");
    // R5 and R6: kept metrics over many blocks, renormalisation along the way
    for (int b = 0; b < 12; b++) begin
      make_noisy(64);
      run_block(2, 0, 0, 64, 1'b0, 0, 1'b0, (b == 3), (b < 6) ? "R5" : "R6");
    end
    // R8: more symbols than the buffer holds
    make_noisy(70);
    run_block(0, 0, 0, 70, 1'b0, 0, 1'b0, 1'b0, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule